// File: doc/BRIEF.md
# Row-Column Addressed Byte Memory

This block is a small static memory of 256 byte-wide locations. Storage is arranged as eight identical bit planes. Each plane is a 16 by 16 grid of single-bit cells, and each plane holds one bit position of every stored byte. All eight planes share one address.

The 8-bit address is split into two halves. The high nibble drives a one-hot row decoder and the low nibble drives a one-hot column decoder. A cell takes part in an access only where its active row line and its active column line cross.

Writes are taken on the rising clock edge. The read path is combinational and is gated by its enable, so a read returns data in the same cycle that it is requested. Locations may be accessed in any order. Reset clears every cell, giving a known power-up state.

Top module: `rc_byte_ram`

## Requirements
- R1: After reset is released, every one of the 256 locations reads back as 8'h00.
- R2: On a rising clock edge with `wr_en` high and `rst_n` high, `wr_data` is stored at location `addr`.
- R3: While `wr_en` is low, no location changes, whatever `addr` and `wr_data` carry.
- R4: While `rd_en` is high, `rd_data` shows the byte stored at `addr` in the same cycle, with no clock edge in between.
- R5: While `rd_en` is low, `rd_data` is 8'h00.
- R6: Address bits [7:4] select the grid row and bits [3:0] select the grid column. Each decoder raises exactly one line. Every one of the 256 addresses is separate storage, so writing one location leaves all others unchanged, including locations that share its row or its column.
- R7: When `rd_en` and `wr_en` are both high in one cycle, `rd_data` returns the contents from before the write during that cycle. The new value appears from the following cycle.
- R8: Each data bit i is kept by its own bit plane. A write with a single bit set stores that bit alone and does not disturb any other bit position.
- R9: Writes and reads may be issued to any address sequence, including descending and random orders, and every read returns the last value written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all cells |
| addr | input | 8 | Location select: row in [7:4], column in [3:0] |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read enable; when low the output is zero |
| rd_data | output | 8 | Byte read from `addr`, or zero when `rd_en` is low |

## Verification
A read and a write can land in the same cycle, and they can target the same address. The bench provokes this case directly on addresses that already hold a known value. It also mixes the case into a long random run, where both enables are drawn independently and addresses are drawn from a small set so that collisions are frequent.

Each such collision is judged twice. The byte sampled before the clock edge must equal the old value held in the bench's model. The next read of that address must return the newly written byte.

// File: rtl/rc_ram_pkg.sv
package rc_ram_pkg;
  parameter int unsigned ROW_BITS_D = 4;
  parameter int unsigned COL_BITS_D = 4;
  parameter int unsigned DATA_W_D   = 8;
  localparam int unsigned ADDR_W_D  = ROW_BITS_D + COL_BITS_D;
endpackage

// File: rtl/rc_onehot_dec.sv
module rc_onehot_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned N_OUT = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code,
  output logic [N_OUT-1:0] lines
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign lines[i] = (code == IN_W'(i));
  end
endmodule

// File: rtl/rc_bit_plane.sv
module rc_bit_plane #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned CELLS = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_line,
  input  logic [COLS-1:0] col_line,
  input  logic            wr_en,
  input  logic            wr_bit,
  output logic            rd_bit
);
  logic [CELLS-1:0] cell_q;
  logic [CELLS-1:0] cross_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      logic sel;
      assign sel = row_line[r] & col_line[c];

      always_ff @(posedge clk) begin
        if (!rst_n)
          cell_q[IDX] <= 1'b0;
        else if (wr_en && sel)
          cell_q[IDX] <= wr_bit;
      end

      assign cross_hit[IDX] = sel & cell_q[IDX];
    end
  end

  assign rd_bit = |cross_hit;
endmodule

// File: rtl/rc_byte_ram.sv
module rc_byte_ram
  import rc_ram_pkg::*;
#(
  parameter int unsigned ROW_BITS = ROW_BITS_D,
  parameter int unsigned COL_BITS = COL_BITS_D,
  parameter int unsigned DATA_W   = DATA_W_D,
  localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS    = 1 << ROW_BITS,
  localparam int unsigned COLS    = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [ROWS-1:0]   row_line;
  logic [COLS-1:0]   col_line;
  logic [DATA_W-1:0] plane_bits;

  rc_onehot_dec #(.IN_W(ROW_BITS)) u_row_dec (
    .code  (addr[ADDR_W-1:COL_BITS]),
    .lines (row_line)
  );

  rc_onehot_dec #(.IN_W(COL_BITS)) u_col_dec (
    .code  (addr[COL_BITS-1:0]),
    .lines (col_line)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    rc_bit_plane #(.ROWS(ROWS), .COLS(COLS)) u_plane (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_line (row_line),
      .col_line (col_line),
      .wr_en    (wr_en),
      .wr_bit   (wr_data[b]),
      .rd_bit   (plane_bits[b])
    );
  end

  assign rd_data = rd_en ? plane_bits : '0;
endmodule

// File: rtl/rc_byte_ram_chk.sv
module rc_byte_ram_chk #(
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned COL_BITS = 4,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS    = 1 << ROW_BITS,
  localparam int unsigned COLS    = 1 << COL_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [ROWS-1:0]   row_line,
  input logic [COLS-1:0]   col_line
);
  // R6: each decoder raises exactly one line
  assert_row_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_line) == 1);
  assert_col_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_line) == 1);

  // R5: output is zero while the read is disabled
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  // R2: a written byte is visible on the next read of the same address
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_en && addr == $past(addr)) -> rd_data == $past(wr_data)));

  // R3: with no write and a steady address, the read value holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> ((rd_en && $stable(addr)) -> $stable(rd_data)));
endmodule

bind rc_byte_ram rc_byte_ram_chk #(
  .ROW_BITS (ROW_BITS),
  .COL_BITS (COL_BITS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .row_line (row_line),
  .col_line (col_line)
);

// File: tb/rc_byte_ram_bench.sv
`timescale 1ns/1ps
module rc_byte_ram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  rc_byte_ram u_rc_byte_ram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic logic [7:0] expect_rd(bit r, logic [7:0] a);
    return r ? model[a] : 8'h00;
  endfunction

  function automatic logic [7:0] fill_val(logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample 2 ns later, model updates at posedge
  task automatic op(bit w, bit r, logic [7:0] a, logic [7:0] d, string tag);
    logic [7:0] e;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    #2;
    e = expect_rd(r, a);
    check(tag, rd_data, e);
    @(posedge clk);
    if (w && rst_n) model[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));

    // reset phase, read disabled must give zero (R5)
    for (int i = 0; i < 3; i++) op(1'b0, 1'b0, 8'(i), 8'hFF, "R5 during reset");
    @(negedge clk); rst_n = 1'b1;

    // R1: all locations zero after reset
    for (int a = 0; a < 256; a++) op(1'b0, 1'b1, 8'(a), 8'h00, "R1 reset contents");

    // R8: single-bit writes, each plane alone
    for (int k = 0; k < 16; k++) op(1'b1, 1'b0, 8'(k * 17), 8'(1 << (k % 8)), "R8 write");
    for (int k = 0; k < 16; k++) op(1'b0, 1'b1, 8'(k * 17), 8'h00, "R8 single bit read");

    // R2/R6: fill every address in ascending order
    for (int a = 0; a < 256; a++) op(1'b1, 1'b0, 8'(a), fill_val(8'(a)), "R2 fill");
    // R9/R6: read back in descending order
    for (int a = 255; a >= 0; a--) op(1'b0, 1'b1, 8'(a), 8'h00, "R9 descending read");

    // R6: overwrite one cell, then check its row and column neighbours
    op(1'b1, 1'b0, 8'h37, 8'hC3, "R6 write");
    for (int j = 0; j < 16; j++) op(1'b0, 1'b1, {4'h3, 4'(j)}, 8'h00, "R6 same row");
    for (int j = 0; j < 16; j++) op(1'b0, 1'b1, {4'(j), 4'h7}, 8'h00, "R6 same column");

    // R3: wr_en low with busy address/data, then verify nothing moved
    for (int i = 0; i < 64; i++) op(1'b0, i[0], 8'($urandom), 8'($urandom), "R3 no write");
    for (int a = 0; a < 256; a += 5) op(1'b0, 1'b1, 8'(a), 8'h00, "R3 unchanged");

    // R5: read disabled returns zero even on non-zero content
    op(1'b0, 1'b0, 8'h37, 8'h00, "R5 idle");

    // R7: simultaneous read and write of one address
    op(1'b1, 1'b1, 8'h80, 8'hA5, "R7 old value");
    op(1'b0, 1'b1, 8'h80, 8'h00, "R7 new value");
    op(1'b1, 1'b1, 8'hFF, 8'h00, "R7 old value top");
    op(1'b1, 1'b1, 8'hFF, 8'h3C, "R7 back to back");
    op(1'b0, 1'b1, 8'hFF, 8'h00, "R7 final");

    // R4/R7/R9: random mix on a narrow address set
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra;
      ra = {4'($urandom % 3), 4'($urandom % 3)};
      op(1'($urandom), 1'($urandom), ra, 8'($urandom), "R4 random mix");
    end

    // final sweep (R9)
    for (int a = 0; a < 256; a++) op(1'b0, 1'b1, 8'(a), 8'h00, "R9 final sweep");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule